// File: doc/BRIEF.md
# Hard Reset Source Router

This block gathers the chip-level hard reset requests and turns them into two reset levels. The power-on level (`rst_l1_o`) covers everything. The system hard reset (`rst_l2_o`) resets the whole chip, including every subsystem and functional module. The power-on request is the block's own asynchronous reset.

A watchdog timeout pulse is steered to one of the two levels, or to neither, by two configuration bits. The active-low external reset pin is asynchronous. It passes a two-flop synchronizer and then a symmetric debounce filter. Only then can it assert or release the system hard reset. The nominal debounce interval is 6.56 ms, set in clock cycles by `DEB_CYCLES`.

Every reset output is stretched to a minimum of `MIN_HOLD` cycles, and it is always released on a clock edge. A sticky register reports the most recent reset cause. Only a power-on request returns it to the power-on code. All pins are plain control and status levels, so no stream handshake is involved.

Top module: `hrst_router`

## Requirements
- R1: While `por_req_i` is high, both `rst_l1_o` and `rst_l2_o` are high and `cause_o` reads 0 (power-on). After `por_req_i` falls, both stay high for exactly `MIN_HOLD` more clock edges' worth of cycles and drop together.
- R2: A one-cycle `wdt_tmo_i` pulse with `hw_wdt_en_i`=1 and `root_rst_en_i`=0 raises `rst_l1_o` on the next clock edge. It then holds `rst_l1_o` for exactly `MIN_HOLD` cycles and releases it synchronously.
- R3: A `wdt_tmo_i` pulse with `root_rst_en_i`=1 raises only `rst_l2_o`, for exactly `MIN_HOLD` cycles. `rst_l1_o` stays low whatever the value of `hw_wdt_en_i`.
- R4: A `wdt_tmo_i` pulse with `hw_wdt_en_i`=0 and `root_rst_en_i`=0 causes no reset and leaves `cause_o` unchanged.
- R5: When `ext_rst_n_i` goes low and stays low for at least `DEB_CYCLES` cycles, `rst_l2_o` rises exactly `DEB_CYCLES`+3 cycles after the first clock edge that sees the low level. That delay is two synchronizer stages, the filter, and the stretch register.
- R6: Release is symmetric. After `ext_rst_n_i` returns high, `rst_l2_o` stays high until `DEB_CYCLES`+2 cycles pass, then for `MIN_HOLD` cycles more, and then falls.
- R7: A pin level that lasts fewer than `DEB_CYCLES` cycles is ignored, whether it asserts from idle or releases during reset. Any return to the settled level restarts the count.
- R8: `cause_o` codes: 0 = power-on, 1 = watchdog to power-on level, 2 = watchdog to hard-reset level, 3 = debounced pin. Each new event overwrites the value, and a watchdog event wins over a pin event in the same cycle. Only `por_req_i` can bring it back to 0.
- R9: Whenever `rst_l1_o` is high, `rst_l2_o` is high as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running reference clock |
| por_req_i | input | 1 | Power-on reset request, active high, asynchronous assert |
| wdt_tmo_i | input | 1 | Watchdog timeout pulse, synchronous to `clk` |
| hw_wdt_en_i | input | 1 | Hardware watchdog reset enable |
| root_rst_en_i | input | 1 | Root reset enable; 1 steers the watchdog to the hard-reset level |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| rst_l1_o | output | 1 | Power-on level reset, active high |
| rst_l2_o | output | 1 | System hard reset, active high |
| cause_o | output | 2 | Sticky last reset cause (codes in R8) |

## Verification
The bench holds the pin low for exactly `DEB_CYCLES`-1 cycles and for exactly `DEB_CYCLES` cycles. A filter that counts off by one either resets on the first of these or misses the second. It also breaks a long low run with a single high cycle, and pulses the pin high briefly during an active reset. A filter that fails to restart its count resets, or releases, too early. The watchdog is sent through all four states of the two steering bits. A router that checks the hardware enable when the root bit is set, or that lets a masked timeout through, gives the wrong level or a changed cause. Exact release cycles catch a stretch counter that holds one cycle too short or too long.

// File: rtl/hrst_pkg.sv
package hrst_pkg;

  typedef enum logic [1:0] {
    CAUSE_POR    = 2'd0,
    CAUSE_WDT_L1 = 2'd1,
    CAUSE_WDT_L2 = 2'd2,
    CAUSE_PIN    = 2'd3
  } cause_e;

endpackage

// File: rtl/hrst_sync.sv
module hrst_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain_q[s] <= RST_VAL;
          else      chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge arst) begin
          if (arst) chain_q[s] <= RST_VAL;
          else      chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hrst_debounce.sv
module hrst_debounce #(
  parameter int CYCLES = 1640000
) (
  input  logic clk,
  input  logic arst,
  input  logic din_i,
  output logic level_o,
  output logic fall_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      level_o <= 1'b1;
      run_q   <= '0;
      fall_o  <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      if (din_i != level_o) begin
        if (run_q == LAST) begin
          level_o <= din_i;
          run_q   <= '0;
          fall_o  <= ~din_i;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  AST_DEB_QUIET: assert property (@(posedge clk) disable iff (arst)
    (din_i == level_o) |=> $stable(level_o)); // R7
  AST_DEB_FALL_LOW: assert property (@(posedge clk) disable iff (arst)
    fall_o |-> !level_o); // R5

endmodule

// File: rtl/hrst_stretch.sv
module hrst_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic req_i,
  output logic active_o
);

  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      active_o <= 1'b1;
      left_q   <= LOAD;
    end else if (req_i) begin
      active_o <= 1'b1;
      left_q   <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      active_o <= 1'b0;
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (arst)
    (active_o && left_q != '0) |=> active_o); // R2
  AST_REQ_RAISES: assert property (@(posedge clk) disable iff (arst)
    req_i |=> active_o); // R2

endmodule

// File: rtl/hrst_router.sv
module hrst_router
  import hrst_pkg::*;
#(
  parameter int DEB_CYCLES = 1640000,
  parameter int MIN_HOLD   = 16
) (
  input  logic       clk,
  input  logic       por_req_i,
  input  logic       wdt_tmo_i,
  input  logic       hw_wdt_en_i,
  input  logic       root_rst_en_i,
  input  logic       ext_rst_n_i,
  output logic       rst_l1_o,
  output logic       rst_l2_o,
  output logic [1:0] cause_o
);

  localparam int SYNC_STAGES = 2;

  logic wdt_to_l1;
  logic wdt_to_l2;
  logic pin_sync;
  logic pin_level;
  logic pin_fall;
  logic l1_act;
  logic l2_act;
  cause_e cause_q;

  assign wdt_to_l1 = wdt_tmo_i & hw_wdt_en_i & ~root_rst_en_i;
  assign wdt_to_l2 = wdt_tmo_i & root_rst_en_i;

  hrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pin_sync (
    .clk  (clk),
    .arst (por_req_i),
    .d_i  (ext_rst_n_i),
    .q_o  (pin_sync)
  );

  hrst_debounce #(.CYCLES(DEB_CYCLES)) i_pin_deb (
    .clk     (clk),
    .arst    (por_req_i),
    .din_i   (pin_sync),
    .level_o (pin_level),
    .fall_o  (pin_fall)
  );

  hrst_stretch #(.HOLD(MIN_HOLD)) i_l1_hold (
    .clk      (clk),
    .arst     (por_req_i),
    .req_i    (wdt_to_l1),
    .active_o (l1_act)
  );

  hrst_stretch #(.HOLD(MIN_HOLD)) i_l2_hold (
    .clk      (clk),
    .arst     (por_req_i),
    .req_i    (wdt_to_l1 | wdt_to_l2 | ~pin_level),
    .active_o (l2_act)
  );

  always_ff @(posedge clk or posedge por_req_i) begin
    if (por_req_i)      cause_q <= CAUSE_POR;
    else if (wdt_to_l1) cause_q <= CAUSE_WDT_L1;
    else if (wdt_to_l2) cause_q <= CAUSE_WDT_L2;
    else if (pin_fall)  cause_q <= CAUSE_PIN;
  end

  assign rst_l1_o = l1_act;
  assign rst_l2_o = l2_act;
  assign cause_o  = cause_q;

  AST_L2_COVERS_L1: assert property (@(posedge clk) disable iff (por_req_i)
    rst_l1_o |-> rst_l2_o); // R9
  AST_WDT_L1: assert property (@(posedge clk) disable iff (por_req_i)
    (wdt_tmo_i && hw_wdt_en_i && !root_rst_en_i) |=> (rst_l1_o && cause_o == CAUSE_WDT_L1)); // R2
  AST_WDT_L2_ONLY: assert property (@(posedge clk) disable iff (por_req_i)
    (wdt_tmo_i && root_rst_en_i && !rst_l1_o) |=> (rst_l2_o && !rst_l1_o)); // R3
  AST_WDT_MASKED: assert property (@(posedge clk) disable iff (por_req_i)
    (wdt_tmo_i && !hw_wdt_en_i && !root_rst_en_i && !pin_fall) |=> $stable(cause_o)); // R4
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_req_i)
    (cause_o != CAUSE_POR) |=> (cause_o != CAUSE_POR)); // R8

endmodule

// File: tb/test_hrst_router.sv
module test_hrst_router;

  localparam int DEB  = 8;
  localparam int HOLD = 4;

  typedef struct {
    int          cyc;
    logic        l1;
    logic        l2;
    logic [1:0]  cs;
    string       tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       por_req_i = 1'b1;
  logic       wdt_tmo_i = 1'b0;
  logic       hw_wdt_en_i = 1'b0;
  logic       root_rst_en_i = 1'b0;
  logic       ext_rst_n_i = 1'b1;
  logic       rst_l1_o;
  logic       rst_l2_o;
  logic [1:0] cause_o;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  exp_t it;

  hrst_router #(.DEB_CYCLES(DEB), .MIN_HOLD(HOLD)) i_hrst_router (
    .clk           (clk),
    .por_req_i     (por_req_i),
    .wdt_tmo_i     (wdt_tmo_i),
    .hw_wdt_en_i   (hw_wdt_en_i),
    .root_rst_en_i (root_rst_en_i),
    .ext_rst_n_i   (ext_rst_n_i),
    .rst_l1_o      (rst_l1_o),
    .rst_l2_o      (rst_l2_o),
    .cause_o       (cause_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare at the falling edge against queued expectations
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      total++;
      if (it.cyc != cyc || rst_l1_o !== it.l1 || rst_l2_o !== it.l2 || cause_o !== it.cs) begin
        bad++;
        $display("FAIL %s cyc=%0d/%0d actual l1=%b l2=%b cause=%0d expected l1=%b l2=%b cause=%0d",
                 it.tag, cyc, it.cyc, rst_l1_o, rst_l2_o, cause_o, it.l1, it.l2, it.cs);
      end
    end
  end

  task automatic expect_at(input int c, input logic l1, input logic l2,
                           input logic [1:0] cs, input string tag);
    exp_t e;
    e.cyc = c; e.l1 = l1; e.l2 = l2; e.cs = cs; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle watchdog pulse with given steering
  task automatic wdt_pulse(input logic en, input logic root, input logic el1,
                           input logic el2, input logic [1:0] ecs, input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    hw_wdt_en_i = en; root_rst_en_i = root; wdt_tmo_i = 1'b1;
    expect_at(c + 1, el1, el2, ecs, tag);
    expect_at(c + HOLD, el1, el2, ecs, tag);
    expect_at(c + HOLD + 1, 1'b0, 1'b0, ecs, tag);
    @(negedge clk);
    wdt_tmo_i = 1'b0;
    step(HOLD + 3);
  endtask

  initial begin
    int c;
    int d;
    step(3);
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b1, 2'd0, "R1 during por");
    step(3);
    c = cyc;
    por_req_i = 1'b0;
    expect_at(c + HOLD - 1, 1'b1, 1'b1, 2'd0, "R1 hold after por");
    expect_at(c + HOLD, 1'b0, 1'b0, 2'd0, "R1 release after por");
    step(HOLD + 3);

    wdt_pulse(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, "R2 wdt to l1 (R9 l2 too)");
    wdt_pulse(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, "R4 masked wdt");
    wdt_pulse(1'b1, 1'b1, 1'b0, 1'b1, 2'd2, "R3 root wins over hw enable");
    wdt_pulse(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, "R8 cause overwrite");
    wdt_pulse(1'b0, 1'b1, 1'b0, 1'b1, 2'd2, "R3 root only");
    wdt_pulse(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, "R2 wdt to l1 again");

    // R7: glitches from idle, each one cycle short, split by one high cycle
    c = cyc;
    ext_rst_n_i = 1'b0;
    expect_at(c + DEB + 3, 1'b0, 1'b0, 2'd1, "R7 short low ignored");
    expect_at(c + 2 * DEB + 4, 1'b0, 1'b0, 2'd1, "R7 restart after glitch");
    step(DEB - 1);
    ext_rst_n_i = 1'b1;
    step(1);
    ext_rst_n_i = 1'b0;
    step(DEB - 1);
    ext_rst_n_i = 1'b1;
    step(DEB + 8);

    // R5: long low assert, R7 short high during reset, R6 release
    c = cyc;
    ext_rst_n_i = 1'b0;
    expect_at(c + DEB + 2, 1'b0, 1'b0, 2'd1, "R5 not before filter");
    expect_at(c + DEB + 3, 1'b0, 1'b1, 2'd3, "R5 pin assert");
    step(DEB + 6);
    c = cyc;
    ext_rst_n_i = 1'b1;
    expect_at(c + DEB + HOLD + 4, 1'b0, 1'b1, 2'd3, "R7 short high keeps reset");
    step(DEB - 1);
    ext_rst_n_i = 1'b0;
    step(DEB + 6);
    d = cyc;
    ext_rst_n_i = 1'b1;
    expect_at(d + DEB + HOLD + 1, 1'b0, 1'b1, 2'd3, "R6 hold before release");
    expect_at(d + DEB + HOLD + 2, 1'b0, 1'b0, 2'd3, "R6 pin release");
    step(DEB + HOLD + 6);

    wdt_pulse(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, "R8 wdt after pin");

    // R5/R6 boundary: low for exactly DEB cycles
    c = cyc;
    ext_rst_n_i = 1'b0;
    expect_at(c + DEB + 2, 1'b0, 1'b0, 2'd1, "R5 boundary not early");
    expect_at(c + DEB + 3, 1'b0, 1'b1, 2'd3, "R5 boundary assert");
    step(DEB);
    ext_rst_n_i = 1'b1;
    d = cyc;
    expect_at(d + DEB + HOLD + 1, 1'b0, 1'b1, 2'd3, "R6 boundary hold");
    expect_at(d + DEB + HOLD + 2, 1'b0, 1'b0, 2'd3, "R6 boundary release");
    step(DEB + HOLD + 6);

    // R1/R8: power-on brings cause back to 0
    c = cyc;
    por_req_i = 1'b1;
    expect_at(c + 1, 1'b1, 1'b1, 2'd0, "R8 por clears cause");
    step(3);
    c = cyc;
    por_req_i = 1'b0;
    expect_at(c + HOLD, 1'b0, 1'b0, 2'd0, "R1 second por release");
    step(HOLD + 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule